// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Sequencer

This block sits between the decoder and the ALU of a 16-bit accumulator-style processor. For each instruction it resolves a source operand and a destination operand, then writes the result back to memory when the destination is in memory. The source can use any of seven addressing modes. The destination can use any of four. Any extension words that follow the opcode are fetched through one word-wide memory port, and the same port carries operand reads and the result write. The program counter is handled as an ordinary register. Immediate mode is an autoincrementing indirect read through the PC, and symbolic mode is indexed addressing based on the PC.

The decoder pulses `start` with the mode fields, the two-operand flag, the source register number and the program counter. The program counter points at the first word after the opcode. While the instruction runs, the register file supplies the current contents of the source and destination registers, and the caller holds them stable. The sequencer walks through a fixed list of steps: source extension, source read, destination extension, destination read, result write. It skips the steps that the mode combination does not need, so the number of cycles follows directly from the modes. The memory port returns read data in the same cycle as the request.

Top module: `ofs_seq`

## Requirements
- R1: Source mode codes are 0 register, 1 indexed (address = Rs + X), 2 symbolic (address = address of the X word + X), 3 absolute (address = X), 4 indirect (address = Rs) and 5 autoincrement (address = Rs). Code 7 behaves as register mode. X is the extension word that follows the opcode. `src_opnd` carries the resulting value.
- R2: Destination mode codes are 0 register, 1 indexed (Rd + X), 2 symbolic (address of the X word + X) and 3 absolute (X). When `two_op` is 1, `dst_opnd` carries the old destination value.
- R3: Extension words are fetched in order: the source word at the PC first, then the destination word at the next word address. `pc_wr` pulses for each fetch, and `pc_wdata` gives the fetch address plus 2.
- R4: Immediate source (code 6) takes the extension word itself as the operand and makes no further read.
- R5: In autoincrement mode, the cycle that reads the operand also raises `ainc_we` with `ainc_idx` equal to the source register number and `ainc_val` equal to Rs + 2. No other mode raises it.
- R6: An instruction takes 1 cycle, plus 1 per extension word, plus 1 per operand read, plus 1 for a memory result write. Every cycle after the first accesses memory. Examples: register to register takes 1 cycle with no access, a memory-to-register move takes 3, a register-to-memory add takes 4, and a memory-to-memory add takes 6.
- R7: A memory destination is written with `result` in the last cycle. A move (`two_op` = 0) skips the destination read. A register destination causes no write.
- R8: `opnd_vld` is high for exactly one cycle, the first one in which both operands are valid. The operands stay valid until `done`.
- R9: `step_cnt` numbers the cycles of an instruction from 1. `done` marks the last cycle. `step_cnt` is 0 while idle.
- R10: After reset, the block is idle with `done`, `opnd_vld` and `mem_en` low and `step_cnt` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (accepted while idle) |
| src_mode | input | 3 | Source addressing mode code |
| dst_mode | input | 2 | Destination addressing mode code |
| two_op | input | 1 | Destination is also read as a source |
| src_idx | input | 4 | Source register number |
| src_reg_val | input | 16 | Current contents of the source register |
| dst_reg_val | input | 16 | Current contents of the destination register |
| pc_in | input | 16 | PC value pointing past the opcode |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, same cycle |
| result | input | 16 | Value to store to a memory destination |
| pc_wr | output | 1 | PC update strobe |
| pc_wdata | output | 16 | New PC value |
| ainc_we | output | 1 | Register increment strobe for autoincrement |
| ainc_idx | output | 4 | Register to increment |
| ainc_val | output | 16 | Incremented register value |
| src_opnd | output | 16 | Source operand |
| dst_opnd | output | 16 | Destination operand |
| opnd_vld | output | 1 | Operands have just become valid |
| done | output | 1 | Last cycle of the instruction |
| step_cnt | output | 3 | Cycle number within the instruction |

## Verification
The hardest case to reach is the one where both operands come from PC-relative extension words. The destination's symbolic address then depends on the source having already consumed a word and moved the PC. The stimulus sweeps all 64 combinations of source code, destination code and `two_op`. Before each run it places the extension words so that every candidate address lands on a distinct word of a patterned memory, so a wrong base or a swapped fetch order shows up as a wrong operand value, a wrong cycle count or a write to the wrong word.

// File: rtl/ofs_pkg.sv
`timescale 1ns/1ps
package ofs_pkg;
  localparam logic [2:0] SM_REG  = 3'd0;
  localparam logic [2:0] SM_IDX  = 3'd1;
  localparam logic [2:0] SM_SYM  = 3'd2;
  localparam logic [2:0] SM_ABS  = 3'd3;
  localparam logic [2:0] SM_IND  = 3'd4;
  localparam logic [2:0] SM_AINC = 3'd5;
  localparam logic [2:0] SM_IMM  = 3'd6;

  localparam logic [1:0] DM_REG = 2'd0;
  localparam logic [1:0] DM_IDX = 2'd1;
  localparam logic [1:0] DM_SYM = 2'd2;
  localparam logic [1:0] DM_ABS = 2'd3;

  typedef enum logic [2:0] {ST_IDLE, ST_SEXT, ST_SRD, ST_DEXT, ST_DRD, ST_WR} step_e;
  typedef enum logic [1:0] {BASE_ZERO, BASE_REG, BASE_PC} base_e;

  typedef struct packed {
    logic  s_reg;
    logic  s_ext;
    logic  s_rd;
    logic  s_imm;
    logic  s_ind;
    logic  s_inc;
    base_e s_base;
    logic  d_reg;
    logic  d_ext;
    logic  d_rd;
    logic  d_wr;
    base_e d_base;
  } plan_t;
endpackage

// File: rtl/ofs_plan.sv
`timescale 1ns/1ps
module ofs_plan
  import ofs_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic [2:0]    smode,
  input  logic [1:0]    dmode,
  input  logic          two_op,
  output plan_t         pl,
  output logic [CW-1:0] total
);
  always_comb begin
    pl = '0;
    case (smode)
      SM_IDX:  begin pl.s_ext = 1'b1; pl.s_rd = 1'b1; pl.s_base = BASE_REG; end
      SM_SYM:  begin pl.s_ext = 1'b1; pl.s_rd = 1'b1; pl.s_base = BASE_PC; end
      SM_ABS:  begin pl.s_ext = 1'b1; pl.s_rd = 1'b1; pl.s_base = BASE_ZERO; end
      SM_IND:  begin pl.s_rd = 1'b1; pl.s_ind = 1'b1; end
      SM_AINC: begin pl.s_rd = 1'b1; pl.s_ind = 1'b1; pl.s_inc = 1'b1; end
      SM_IMM:  begin pl.s_ext = 1'b1; pl.s_imm = 1'b1; end
      default: pl.s_reg = 1'b1;
    endcase
    case (dmode)
      DM_IDX:  begin pl.d_ext = 1'b1; pl.d_base = BASE_REG; end
      DM_SYM:  begin pl.d_ext = 1'b1; pl.d_base = BASE_PC; end
      DM_ABS:  begin pl.d_ext = 1'b1; pl.d_base = BASE_ZERO; end
      default: pl.d_reg = 1'b1;
    endcase
    pl.d_rd = pl.d_ext & two_op;
    pl.d_wr = pl.d_ext;
  end

  assign total = CW'(1) + CW'(pl.s_ext) + CW'(pl.s_rd) + CW'(pl.d_ext)
               + CW'(pl.d_rd) + CW'(pl.d_wr);
endmodule

// File: rtl/ofs_step.sv
`timescale 1ns/1ps
module ofs_step
  import ofs_pkg::*;
(
  input  step_e cur,
  input  plan_t pl,
  output step_e nxt
);
  always_comb begin
    nxt = ST_IDLE;
    case (cur)
      ST_IDLE: nxt = pl.s_ext ? ST_SEXT : pl.s_rd ? ST_SRD : pl.d_ext ? ST_DEXT : ST_IDLE;
      ST_SEXT: nxt = pl.s_rd ? ST_SRD : pl.d_ext ? ST_DEXT : ST_IDLE;
      ST_SRD:  nxt = pl.d_ext ? ST_DEXT : ST_IDLE;
      ST_DEXT: nxt = pl.d_rd ? ST_DRD : pl.d_wr ? ST_WR : ST_IDLE;
      ST_DRD:  nxt = pl.d_wr ? ST_WR : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/ofs_agen.sv
`timescale 1ns/1ps
module ofs_agen
  import ofs_pkg::*;
#(
  parameter int DW = 16
) (
  input  base_e         base,
  input  logic [DW-1:0] reg_val,
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] ext,
  output logic [DW-1:0] addr
);
  logic [DW-1:0] base_val;
  always_comb begin
    case (base)
      BASE_REG: base_val = reg_val;
      BASE_PC:  base_val = pc;
      default:  base_val = '0;
    endcase
  end
  assign addr = base_val + ext;
endmodule

// File: rtl/ofs_seq.sv
`timescale 1ns/1ps
module ofs_seq
  import ofs_pkg::*;
#(
  parameter int DW = 16,
  parameter int RW = 4,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    src_mode,
  input  logic [1:0]    dst_mode,
  input  logic          two_op,
  input  logic [RW-1:0] src_idx,
  input  logic [DW-1:0] src_reg_val,
  input  logic [DW-1:0] dst_reg_val,
  input  logic [DW-1:0] pc_in,
  output logic          mem_en,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] result,
  output logic          pc_wr,
  output logic [DW-1:0] pc_wdata,
  output logic          ainc_we,
  output logic [RW-1:0] ainc_idx,
  output logic [DW-1:0] ainc_val,
  output logic [DW-1:0] src_opnd,
  output logic [DW-1:0] dst_opnd,
  output logic          opnd_vld,
  output logic          done,
  output logic [CW-1:0] step_cnt
);
  localparam logic [DW-1:0] ADV = DW'(DW / 8);

  logic [1:0]    rst_q;
  logic          rst_i;
  step_e         st_q, st_d, cur, nxt;
  plan_t         pln_in, pln_q, pln_c;
  logic [CW-1:0] total, cnt_q;
  logic [RW-1:0] sidx_q;
  logic [DW-1:0] pc_q, saddr_q, daddr_q, src_q, dst_q;
  logic [DW-1:0] s_addr, d_addr;
  logic          idle, act, accept;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  ofs_plan #(.CW(CW)) u_plan (
    .smode(src_mode), .dmode(dst_mode), .two_op(two_op), .pl(pln_in), .total(total)
  );

  assign idle   = (st_q == ST_IDLE);
  assign accept = idle & start;
  assign act    = accept | ~idle;
  assign pln_c  = idle ? pln_in : pln_q;
  assign cur    = idle ? ST_IDLE : st_q;

  ofs_step u_step (.cur(cur), .pl(pln_c), .nxt(nxt));

  ofs_agen #(.DW(DW)) u_agen_src (
    .base(pln_q.s_base), .reg_val(src_reg_val), .pc(pc_q), .ext(mem_rdata), .addr(s_addr)
  );
  ofs_agen #(.DW(DW)) u_agen_dst (
    .base(pln_q.d_base), .reg_val(dst_reg_val), .pc(pc_q), .ext(mem_rdata), .addr(d_addr)
  );

  // next state
  assign st_d     = act ? nxt : ST_IDLE;
  assign done     = act & (nxt == ST_IDLE);
  assign opnd_vld = act & (st_q != ST_WR) & ((nxt == ST_IDLE) | (nxt == ST_WR));
  assign step_cnt = idle ? (start ? CW'(1) : CW'(0)) : cnt_q;

  // memory port
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st_q)
      ST_SEXT, ST_DEXT: begin mem_en = 1'b1; mem_addr = pc_q; end
      ST_SRD:  begin mem_en = 1'b1; mem_addr = pln_q.s_ind ? src_reg_val : saddr_q; end
      ST_DRD:  begin mem_en = 1'b1; mem_addr = daddr_q; end
      ST_WR:   begin mem_en = 1'b1; mem_we = 1'b1; mem_addr = daddr_q; mem_wdata = result; end
      default: ;
    endcase
  end

  assign pc_wr    = (st_q == ST_SEXT) | (st_q == ST_DEXT);
  assign pc_wdata = pc_q + ADV;
  assign ainc_we  = (st_q == ST_SRD) & pln_q.s_inc;
  assign ainc_idx = sidx_q;
  assign ainc_val = src_reg_val + ADV;

  assign src_opnd = pln_c.s_reg ? src_reg_val :
                    ((st_q == ST_SRD) | ((st_q == ST_SEXT) & pln_q.s_imm)) ? mem_rdata : src_q;
  assign dst_opnd = pln_c.d_reg ? dst_reg_val : (st_q == ST_DRD) ? mem_rdata : dst_q;

  // control registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept)     cnt_q <= CW'(2);
      else if (!idle) cnt_q <= cnt_q + CW'(1);
    end
  end

  // data registers, enabled only
  always_ff @(posedge clk) begin
    if (accept) begin
      pln_q  <= pln_in;
      sidx_q <= src_idx;
    end
    if (accept)     pc_q <= pc_in;
    else if (pc_wr) pc_q <= pc_wdata;
    if (st_q == ST_SEXT) saddr_q <= s_addr;
    if (st_q == ST_DEXT) daddr_q <= d_addr;
    if ((st_q == ST_SRD) | ((st_q == ST_SEXT) & pln_q.s_imm)) src_q <= mem_rdata;
    if (st_q == ST_DRD) dst_q <= mem_rdata;
  end

  // R3
  ext_order_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == ST_SEXT && st_d == ST_DEXT) |=> (mem_addr == $past(mem_addr) + ADV));

  // R7
  wr_after_access_chk: assert property (@(posedge clk) disable iff (!rst_i)
    mem_we |-> $past(mem_en));

  // R5
  ainc_with_read_chk: assert property (@(posedge clk) disable iff (!rst_i)
    ainc_we |-> (mem_en && !mem_we));

  // R8
  vld_then_write_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (opnd_vld && !done) |=> mem_we);

  // R6
  cycle_total_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (done && !idle) |-> (step_cnt == CW'(1) + CW'(pln_q.s_ext) + CW'(pln_q.s_rd)
                         + CW'(pln_q.d_ext) + CW'(pln_q.d_rd) + CW'(pln_q.d_wr)));

  // R6
  start_total_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (accept && done) |-> (total == CW'(1)));
endmodule

// File: tb/ofs_seq_tb.sv
`timescale 1ns/1ps
module ofs_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  src_mode;
  logic [1:0]  dst_mode;
  logic        two_op;
  logic [3:0]  src_idx;
  logic [15:0] src_reg_val, dst_reg_val, pc_in;
  logic        mem_en, mem_we, pc_wr, ainc_we, opnd_vld, done;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, result, pc_wdata, ainc_val, src_opnd, dst_opnd;
  logic [3:0]  ainc_idx;
  logic [2:0]  step_cnt;

  logic [15:0] mem [256];
  int total_n = 0;
  int bad_n   = 0;

  localparam logic [15:0] PC0 = 16'h0040;
  localparam logic [15:0] SX  = 16'h0006;
  localparam logic [15:0] DX  = 16'h000C;
  localparam logic [15:0] SRV = 16'h0080;
  localparam logic [15:0] DRV = 16'h00A0;

  always #2.5 clk = ~clk;

  ofs_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_mode(src_mode), .dst_mode(dst_mode),
    .two_op(two_op), .src_idx(src_idx), .src_reg_val(src_reg_val), .dst_reg_val(dst_reg_val),
    .pc_in(pc_in), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .result(result), .pc_wr(pc_wr), .pc_wdata(pc_wdata),
    .ainc_we(ainc_we), .ainc_idx(ainc_idx), .ainc_val(ainc_val), .src_opnd(src_opnd),
    .dst_opnd(dst_opnd), .opnd_vld(opnd_vld), .done(done), .step_cnt(step_cnt)
  );

  assign mem_rdata = mem[mem_addr[8:1]];
  assign result    = two_op ? (src_opnd + dst_opnd) : src_opnd;

  always @(posedge clk) if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;

  function automatic logic [15:0] pat(input logic [15:0] byte_addr);
    return 16'hC000 | 16'(byte_addr[8:1] * 3);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total_n++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [2:0] sm, input logic [1:0] dm, input logic to);
    logic se, sr, de, fin;
    int exp_tot, cyc, rd_n, we_n, ext_n, inc_n, vld_n;
    logic [15:0] exp_s, exp_d, daddr, pd, got_s, got_d, exp_w;
    se = (sm == 3'd1) || (sm == 3'd2) || (sm == 3'd3) || (sm == 3'd6);
    sr = (sm >= 3'd1) && (sm <= 3'd5);
    de = (dm != 2'd0);
    exp_tot = 1 + int'(se) + int'(sr) + int'(de) + int'(de && to) + int'(de);
    for (int k = 0; k < 256; k++) mem[k] = pat(16'(k * 2));
    if (se) begin
      mem[PC0[8:1]] = SX;
      if (de) mem[PC0[8:1] + 8'd1] = DX;
    end else if (de) mem[PC0[8:1]] = DX;
    case (sm)
      3'd1: exp_s = pat(SRV + SX);
      3'd2: exp_s = pat(PC0 + SX);
      3'd3: exp_s = pat(SX);
      3'd4, 3'd5: exp_s = pat(SRV);
      3'd6: exp_s = SX;
      default: exp_s = SRV;
    endcase
    pd = PC0 + (se ? 16'd2 : 16'd0);
    case (dm)
      2'd1: daddr = DRV + DX;
      2'd2: daddr = pd + DX;
      default: daddr = DX;
    endcase
    exp_d = de ? pat(daddr) : DRV;
    exp_w = to ? exp_s + exp_d : exp_s;

    @(negedge clk);
    src_mode = sm; dst_mode = dm; two_op = to; start = 1'b1;
    cyc = 0; rd_n = 0; we_n = 0; ext_n = 0; inc_n = 0; vld_n = 0; fin = 1'b0;
    got_s = '0; got_d = '0;
    while (!fin && cyc < 20) begin
      #1;
      cyc++;
      check(step_cnt == 3'(cyc), "R9 step number", step_cnt, cyc);
      if (mem_en) rd_n++;
      if (mem_we) we_n++;
      if (pc_wr) begin
        check(mem_addr == PC0 + 16'(2 * ext_n), "R3 fetch address", mem_addr, PC0 + 16'(2 * ext_n));
        check(pc_wdata == PC0 + 16'(2 * ext_n + 2), "R3 pc advance", pc_wdata, PC0 + 16'(2 * ext_n + 2));
        ext_n++;
      end
      if (ainc_we) begin
        inc_n++;
        check(ainc_val == SRV + 16'd2, "R5 increment value", ainc_val, SRV + 16'd2);
        check(ainc_idx == 4'd7, "R5 increment index", ainc_idx, 4'd7);
      end
      if (opnd_vld) begin vld_n++; got_s = src_opnd; got_d = dst_opnd; end
      if (done) fin = 1'b1;
      if (!opnd_vld && vld_n == 1) begin
        check(src_opnd == got_s, "R8 source held", src_opnd, got_s);
      end
      @(negedge clk);
      start = 1'b0;
    end
    check(fin, "R6 completion", fin, 1);
    check(cyc == exp_tot, "R6 cycle count", cyc, exp_tot);
    check(rd_n == exp_tot - 1, "R6 access cycles", rd_n, exp_tot - 1);
    check(we_n == int'(de), "R7 write count", we_n, int'(de));
    check(vld_n == 1, "R8 valid pulses", vld_n, 1);
    check(ext_n == int'(se) + int'(de), "R3 extension count", ext_n, int'(se) + int'(de));
    check(inc_n == int'(sm == 3'd5), "R5 increment count", inc_n, int'(sm == 3'd5));
    if (sm == 3'd6) check(got_s == exp_s, "R4 immediate operand", got_s, exp_s);
    else            check(got_s == exp_s, "R1 source operand", got_s, exp_s);
    if (to) check(got_d == exp_d, "R2 destination operand", got_d, exp_d);
    if (de) check(mem[daddr[8:1]] == exp_w, "R7 stored result", mem[daddr[8:1]], exp_w);
    #1;
    check(step_cnt == 3'd0 && !done, "R9 idle after done", step_cnt, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad_n++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; src_mode = '0; dst_mode = '0; two_op = 1'b0;
    src_idx = 4'd7; src_reg_val = SRV; dst_reg_val = DRV; pc_in = PC0;
    repeat (3) @(negedge clk);
    #1;
    check(!done && !opnd_vld && !mem_en && step_cnt == 3'd0, "R10 reset state",
          {done, opnd_vld, mem_en, step_cnt}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int s = 0; s < 8; s++)
      for (int d = 0; d < 4; d++)
        for (int t = 0; t < 2; t++)
          run_one(3'(s), 2'(d), t[0]);
    $display("  test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end
endmodule